// File: doc/BRIEF.md
# Host I/O and Sound Command Port

This block is a memory-mapped slave on a 16-bit host bus with 24-bit byte addressing. It answers reads in a small sixteen-byte I/O window. Each mapped word in that window carries a view of the player inputs or the configuration switch banks, packed into 16 bits. All inputs are active low and pass through without inversion: an idle input reads 1 and a pressed input reads 0. Mapped words with no port behind them, and the unused byte lanes, read as zero.

The block also serves as a one-byte mailbox to a secondary sound processor. A host write to the command address stores the upper data byte and raises an interrupt request toward the sound processor. The sound processor fetches the byte through its own 8-bit read port, and that fetch withdraws the request. If the host writes again while the request is still pending, the byte is overwritten and the request stays up. The block has no software-visible status.

Top module: `host_io_port`

## Requirements
- R1: A host read of word 0 of the window (byte address 0x080000 or 0x080001) returns the coin/start port in bits 7:0 and zero in bits 15:8, with host_ack high in the cycle after the read.
- R2: A host read of word 1 (byte 0x080002) returns player 1 in bits 7:0 and player 2 in bits 15:8.
- R3: A host read of word 4 (byte 0x080008) returns switch bank B in bits 15:8 and zero in bits 7:0.
- R4: A host read of word 5 (byte 0x08000A) returns switch bank A in bits 7:0 and zero in bits 15:8.
- R5: A host read of words 2, 3, 6 or 7 of the window returns 0x0000 and is still acknowledged. A read outside 0x080000 to 0x08000F is not acknowledged.
- R6: Input bits are reported exactly as driven, with no inversion, so an all-ones port reads as all ones.
- R7: A host write to byte address 0x084000 or 0x084001 is acknowledged, stores data bits 15:8 in the command latch and sets snd_irq in the next cycle. A write to any other address leaves the latch unchanged and is not acknowledged.
- R8: A sound read at address 0xA000 returns the latch on snd_rdata in the next cycle and clears snd_irq.
- R9: A host write while snd_irq is pending overwrites the latch and keeps snd_irq high.
- R10: When a host command write and a sound latch read fall in the same cycle, snd_irq stays set and the new byte is held for the next sound read.
- R11: A sound read at any address other than 0xA000 leaves snd_irq unchanged.
- R12: After reset the latch holds 0x00, snd_irq is low and host_ack is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 24 | Host byte address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| host_ack | output | 1 | Access completed by this slave |
| coin_start_n | input | 8 | Coin and start inputs, active low |
| p1_n | input | 8 | Player 1 controls, active low |
| p2_n | input | 8 | Player 2 controls, active low |
| sw_a_n | input | 8 | Switch bank A, active low |
| sw_b_n | input | 8 | Switch bank B, active low |
| snd_addr | input | 16 | Sound processor address |
| snd_rd | input | 1 | Sound processor read strobe |
| snd_rdata | output | 8 | Registered command byte for the sound processor |
| snd_irq | output | 1 | Interrupt request to the sound processor |

## Verification
Every result is due exactly one cycle after the strobe that causes it. Host read data and host_ack, the latch content seen on snd_rdata, and each change of snd_irq are all registered at the edge that samples the strobe. The driver asserts a strobe for one cycle after a falling edge and queues the expected value at the same moment. The monitor pops one item a quarter period after the following rising edge, so every comparison lands in the cycle the result becomes valid and before the next stimulus changes it.

// File: rtl/host_io_pkg.sv
package host_io_pkg;
  localparam int HADDR_W  = 24;
  localparam int DATA_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int SADDR_W  = 16;
  localparam int WIN_BITS = 4;
  localparam int IDX_W    = WIN_BITS - 1;

  localparam logic [HADDR_W-1:0] IO_BASE   = 24'h080000;
  localparam logic [HADDR_W-1:0] CMD_ADDR  = 24'h084000;
  localparam logic [SADDR_W-1:0] SND_LATCH = 16'hA000;

  typedef enum logic [IDX_W-1:0] {
    W_COIN  = 3'd0,
    W_PLAY  = 3'd1,
    W_SW_B  = 3'd4,
    W_SW_A  = 3'd5
  } io_word_e;

  function automatic logic idx_mapped(input logic [IDX_W-1:0] idx);
    return (idx == W_COIN) || (idx == W_PLAY) || (idx == W_SW_B) || (idx == W_SW_A);
  endfunction

  function automatic logic [DATA_W-1:0] pack_word(
    input logic [IDX_W-1:0]  idx,
    input logic [BYTE_W-1:0] coin,
    input logic [BYTE_W-1:0] p1,
    input logic [BYTE_W-1:0] p2,
    input logic [BYTE_W-1:0] sa,
    input logic [BYTE_W-1:0] sb
  );
    logic [DATA_W-1:0] w;
    w = '0;
    case (idx)
      W_COIN:  w = {{BYTE_W{1'b0}}, coin};
      W_PLAY:  w = {p2, p1};
      W_SW_B:  w = {sb, {BYTE_W{1'b0}}};
      W_SW_A:  w = {{BYTE_W{1'b0}}, sa};
      default: w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/io_window_decode.sv
module io_window_decode
  import host_io_pkg::*;
(
  input  logic [HADDR_W-1:0] addr,
  input  logic               rd,
  input  logic               wr,
  output logic               rd_hit,
  output logic               wr_hit,
  output logic [IDX_W-1:0]   word_idx
);
  logic in_window;
  logic on_cmd;

  assign in_window = (addr[HADDR_W-1:WIN_BITS] == IO_BASE[HADDR_W-1:WIN_BITS]);
  assign on_cmd    = (addr[HADDR_W-1:1] == CMD_ADDR[HADDR_W-1:1]);
  assign rd_hit    = rd && in_window;
  assign wr_hit    = wr && on_cmd;
  assign word_idx  = addr[WIN_BITS-1:1];
endmodule

// File: rtl/io_read_pack.sv
module io_read_pack
  import host_io_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_hit,
  input  logic               wr_hit,
  input  logic [IDX_W-1:0]   word_idx,
  input  logic [BYTE_W-1:0]  coin_start_n,
  input  logic [BYTE_W-1:0]  p1_n,
  input  logic [BYTE_W-1:0]  p2_n,
  input  logic [BYTE_W-1:0]  sw_a_n,
  input  logic [BYTE_W-1:0]  sw_b_n,
  output logic [DATA_W-1:0]  rdata,
  output logic               ack
);
  logic unmapped_rd;
  logic [DATA_W-1:0] word_nxt;

  assign unmapped_rd = rd_hit && !idx_mapped(word_idx);
  assign word_nxt    = pack_word(word_idx, coin_start_n, p1_n, p2_n, sw_a_n, sw_b_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      ack   <= 1'b0;
    end else begin
      rdata <= rd_hit ? word_nxt : '0;
      ack   <= rd_hit || wr_hit;
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> (rdata == '0)); // R5
  AST_ACK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit || wr_hit) |=> ack); // R5
  AST_NO_ACK_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_hit || wr_hit) |=> !ack); // R5
endmodule

// File: rtl/snd_cmd_latch.sv
module snd_cmd_latch
  import host_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              snd_fetch,
  output logic [BYTE_W-1:0] snd_rdata,
  output logic              snd_irq
);
  logic [BYTE_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      snd_irq   <= 1'b0;
      snd_rdata <= '0;
    end else begin
      if (cmd_wr) cmd_q <= cmd_byte;
      if (cmd_wr)         snd_irq <= 1'b1;
      else if (snd_fetch) snd_irq <= 1'b0;
      snd_rdata <= snd_fetch ? cmd_q : '0;
    end
  end

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> snd_irq); // R7
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_fetch && !cmd_wr) |=> !snd_irq); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_irq && !snd_fetch) |=> snd_irq); // R11
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_q)); // R7
endmodule

// File: rtl/host_io_port.sv
module host_io_port
  import host_io_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [23:0]        host_addr,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               host_ack,
  input  logic [7:0]         coin_start_n,
  input  logic [7:0]         p1_n,
  input  logic [7:0]         p2_n,
  input  logic [7:0]         sw_a_n,
  input  logic [7:0]         sw_b_n,
  input  logic [15:0]        snd_addr,
  input  logic               snd_rd,
  output logic [7:0]         snd_rdata,
  output logic               snd_irq
);
  logic             rd_hit;
  logic             wr_hit;
  logic [IDX_W-1:0] word_idx;
  logic             snd_fetch;

  assign snd_fetch = snd_rd && (snd_addr == SND_LATCH);

  io_window_decode u_dec (
    .addr     (host_addr),
    .rd       (host_rd),
    .wr       (host_wr),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .word_idx (word_idx)
  );

  io_read_pack u_pack (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_hit       (rd_hit),
    .wr_hit       (wr_hit),
    .word_idx     (word_idx),
    .coin_start_n (coin_start_n),
    .p1_n         (p1_n),
    .p2_n         (p2_n),
    .sw_a_n       (sw_a_n),
    .sw_b_n       (sw_b_n),
    .rdata        (host_rdata),
    .ack          (host_ack)
  );

  snd_cmd_latch u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (wr_hit),
    .cmd_byte  (host_wdata[DATA_W-1:BYTE_W]),
    .snd_fetch (snd_fetch),
    .snd_rdata (snd_rdata),
    .snd_irq   (snd_irq)
  );

  AST_FETCH_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_fetch && wr_hit) |=> snd_irq); // R10
endmodule

// File: tb/host_io_port_test.sv
module host_io_port_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] host_addr = '0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ack;
  logic [7:0]  coin_start_n = 8'hFF;
  logic [7:0]  p1_n = 8'hFF;
  logic [7:0]  p2_n = 8'hFF;
  logic [7:0]  sw_a_n = 8'hFF;
  logic [7:0]  sw_b_n = 8'hFF;
  logic [15:0] snd_addr = '0;
  logic        snd_rd = 1'b0;
  logic [7:0]  snd_rdata;
  logic        snd_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    string       req;
    bit          is_snd;
    bit          use_data;
    bit          use_ack;
    bit          use_irq;
    logic [15:0] exp_data;
    logic        exp_ack;
    logic        exp_irq;
  } item_t;

  item_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  host_io_port uut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
    .coin_start_n(coin_start_n), .p1_n(p1_n), .p2_n(p2_n),
    .sw_a_n(sw_a_n), .sw_b_n(sw_b_n),
    .snd_addr(snd_addr), .snd_rd(snd_rd), .snd_rdata(snd_rdata), .snd_irq(snd_irq)
  );

  // Expected word for an offset in the window, written from the requirements
  function automatic logic [15:0] model_word(input logic [23:0] a);
    logic [3:0] off;
    off = {a[3:1], 1'b0};
    if (off == 4'h0) return {8'h00, coin_start_n};
    if (off == 4'h2) return {p2_n, p1_n};
    if (off == 4'h8) return {sw_b_n, 8'h00};
    if (off == 4'hA) return {8'h00, sw_a_n};
    return 16'h0000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    host_rd = 1'b0; host_wr = 1'b0; snd_rd = 1'b0;
  endtask

  task automatic host_read(input string req, input logic [23:0] a);
    item_t it;
    @(negedge clk);
    idle_strobes();
    host_addr = a; host_rd = 1'b1;
    it = '{req: req, is_snd: 0, use_data: 1, use_ack: 1, use_irq: 0,
           exp_data: model_word(a), exp_ack: 1'b1, exp_irq: 1'b0};
    if (a[23:4] != 20'h08000) begin it.use_data = 0; it.exp_ack = 1'b0; end
    sb_q.push_back(it);
  endtask

  task automatic host_write(input string req, input logic [23:0] a, input logic [15:0] d,
                            input logic also_fetch, input logic exp_ack, input logic exp_irq);
    item_t it;
    @(negedge clk);
    idle_strobes();
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    snd_addr = 16'hA000; snd_rd = also_fetch;
    it = '{req: req, is_snd: 0, use_data: 0, use_ack: 1, use_irq: 1,
           exp_data: 16'h0, exp_ack: exp_ack, exp_irq: exp_irq};
    sb_q.push_back(it);
  endtask

  task automatic snd_read(input string req, input logic [15:0] a, input logic check_data,
                          input logic [7:0] exp_byte, input logic exp_irq);
    item_t it;
    @(negedge clk);
    idle_strobes();
    snd_addr = a; snd_rd = 1'b1;
    it = '{req: req, is_snd: 1, use_data: check_data, use_ack: 0, use_irq: 1,
           exp_data: {8'h00, exp_byte}, exp_ack: 1'b0, exp_irq: exp_irq};
    sb_q.push_back(it);
  endtask

  task automatic go_idle();
    @(negedge clk);
    idle_strobes();
  endtask

  // Monitor: one item per rising edge, sampled a quarter period later
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.use_data)
          check(it.req, it.is_snd ? {8'h00, snd_rdata} : host_rdata, it.exp_data);
        if (it.use_ack) check({it.req, " ack"}, {15'h0, host_ack}, {15'h0, it.exp_ack});
        if (it.use_irq) check({it.req, " irq"}, {15'h0, snd_irq}, {15'h0, it.exp_irq});
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check("R12 reset ack", {15'h0, host_ack}, 16'h0);
    check("R12 reset irq", {15'h0, snd_irq}, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    snd_read("R12 reset latch", 16'hA000, 1'b1, 8'h00, 1'b0);

    coin_start_n = 8'hE6; p1_n = 8'h5A; p2_n = 8'hC3; sw_a_n = 8'h7E; sw_b_n = 8'hB1;
    host_read("R1 coin word", 24'h080000);
    host_read("R1 coin word odd byte", 24'h080001);
    host_read("R2 players", 24'h080002);
    host_read("R3 bank B", 24'h080008);
    host_read("R4 bank A", 24'h08000A);
    host_read("R5 unmapped 4", 24'h080004);
    host_read("R5 unmapped 6", 24'h080006);
    host_read("R5 unmapped C", 24'h08000C);
    host_read("R5 unmapped E", 24'h08000E);
    host_read("R5 outside window", 24'h080010);
    go_idle();

    coin_start_n = 8'hFF; p1_n = 8'hFF; p2_n = 8'hFF; sw_a_n = 8'hFF; sw_b_n = 8'hFF;
    host_read("R6 idle coin", 24'h080000);
    host_read("R6 idle players", 24'h080002);
    host_read("R6 idle bank B", 24'h080008);
    p1_n = 8'h00; p2_n = 8'h01;
    host_read("R6 pressed players", 24'h080002);
    go_idle();

    host_write("R7 stray write", 24'h084002, 16'h9900, 1'b0, 1'b0, 1'b0);
    snd_read("R7 latch untouched", 16'hA000, 1'b1, 8'h00, 1'b0);
    host_write("R7 command write", 24'h084000, 16'h3C77, 1'b0, 1'b1, 1'b1);
    snd_read("R11 other sound addr", 16'hA001, 1'b0, 8'h00, 1'b1);
    go_idle();
    snd_read("R8 fetch byte", 16'hA000, 1'b1, 8'h3C, 1'b0);
    host_write("R7 write odd byte addr", 24'h084001, 16'h4211, 1'b0, 1'b1, 1'b1);
    host_write("R9 overwrite pending", 24'h084000, 16'hA5FF, 1'b0, 1'b1, 1'b1);
    snd_read("R9 newest byte", 16'hA000, 1'b1, 8'hA5, 1'b0);
    host_write("R7 before collide", 24'h084000, 16'h1200, 1'b0, 1'b1, 1'b1);
    host_write("R10 collide", 24'h084000, 16'h6E00, 1'b1, 1'b1, 1'b1);
    snd_read("R10 new byte kept", 16'hA000, 1'b1, 8'h6E, 1'b0);
    go_idle();
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule